// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-beat requests from an on-chip master into cycles on an external parallel memory bus. Eight pins carry, in turn, the low address byte and the data byte. A latch-enable strobe (ALE) is high while the low address is on those pins, so an external latch can capture it on the falling edge. A separate group of pins carries the high address byte. Active-low read and write strobes complete the bus.

The external space is split at a programmable boundary into a lower and an upper sector, and each sector has its own 2-bit wait code. An enable bit gives the controller ownership of every bus pin. While the bit is clear, each pin passes through the general-purpose value and direction supplied by the rest of the chip. Three configuration registers sit behind a small write-only control port.

Requests use valid/ready. `req_ready` is high only while the controller is enabled and idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The master must hold its fields stable until that edge. The response is a one-cycle `rsp_valid` pulse with no back-pressure, and the consumer must take it in that cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, every configuration field is zero. The pad outputs and enables equal the general-purpose inputs. `req_ready` and `rsp_valid` are low.
- R2: Configuration writes use `cfg_we` with `cfg_addr`:
  - Address 0, bit 0, is the enable bit.
  - Address 1, bits 2:0, is the sector limit.
  - Address 2 holds the lower-sector wait code in bits 1:0 and the upper-sector wait code in bits 3:2.
  
  While the enable bit is set, `pad_hi_oe` is all ones and `pad_ctl_oe` is 3'b111. Control pins are ordered [2]=ALE, [1]=write strobe (active low), [0]=read strobe (active low). While the enable bit is clear, every pad follows its general-purpose input.
- R3: Cycles are counted from the accepting edge. In cycle 1, ALE is high, the low-byte pins drive `req_addr[7:0]` and `pad_hi_out` drives `req_addr[15:8]`. In cycle 2, ALE is low and the low address is still driven.
- R4: From cycle 3, exactly one strobe is low: the write strobe for writes, the read strobe for reads. It stays low for 1 + min(code, 2) cycles. ALE is low throughout the strobe. During a write strobe the low-byte pins drive the write data with all enables set. During a read strobe the enables of the low-byte pins are all zero.
- R5: `rsp_valid` is high for exactly one cycle, in cycle 4 + code.
- R6: For reads, `rsp_rdata` equals `pad_ad_in` as sampled on the clock edge at which the read strobe rises.
- R7: The wait code depends on the sector:
  - With limit 0, the lower-sector code applies to every address.
  - With limit k in 1..7, an address at or above 0x0260 + k*0x2000 uses the upper-sector code, and any lower address uses the lower-sector code.
- R8: With code 3, one extra cycle follows the strobe. In it, ALE is high and the low-byte pins drive the next request's `req_addr[7:0]` only if `req_valid` is high in that cycle. Otherwise ALE stays low.
- R9: `req_ready` is low from cycle 1 until the response cycle. The wait code is fixed when the request is accepted, so a configuration write during an access does not change that access's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data |
| gp_ad_out | input | 8 | General-purpose value, low-byte pins |
| gp_ad_oe | input | 8 | General-purpose enables, low-byte pins |
| gp_hi_out | input | 8 | General-purpose value, high-address pins |
| gp_hi_oe | input | 8 | General-purpose enables, high-address pins |
| gp_ctl_out | input | 3 | General-purpose value, control pins |
| gp_ctl_oe | input | 3 | General-purpose enables, control pins |
| pad_ad_in | input | 8 | Value seen on the low-byte pins |
| pad_ad_out | output | 8 | Low-byte pin value |
| pad_ad_oe | output | 8 | Low-byte pin enables |
| pad_hi_out | output | 8 | High-address pin value |
| pad_hi_oe | output | 8 | High-address pin enables |
| pad_ctl_out | output | 3 | Control pin values (ALE, write, read) |
| pad_ctl_oe | output | 3 | Control pin enables |

## Verification
Two functions can fall in the same cycle. The trailing-ALE decision of a code-3 access is taken in the tail cycle, and that is also the cycle in which a new request may arrive. The bench raises `req_valid` for a second access exactly at that cycle. It checks that ALE and the next low address appear, and that the second access then runs with its own timing. A second collision is a configuration write made during a running access. The bench judges it by measuring that access's latency, which must not move.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_STRB,
    ST_TAIL
  } xb_state_e;

  localparam logic [1:0] CFG_EN   = 2'd0;
  localparam logic [1:0] CFG_LIM  = 2'd1;
  localparam logic [1:0] CFG_WAIT = 2'd2;
endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg #(
  parameter int LIM_W = 3,
  parameter int WC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic             en,
  output logic [LIM_W-1:0] lim,
  output logic [WC_W-1:0]  wc_lo,
  output logic [WC_W-1:0]  wc_hi
);
  import xbus_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      lim   <= '0;
      wc_lo <= '0;
      wc_hi <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_EN:   en  <= cfg_wdata[0];
        CFG_LIM:  lim <= cfg_wdata[LIM_W-1:0];
        CFG_WAIT: begin
          wc_lo <= cfg_wdata[WC_W-1:0];
          wc_hi <= cfg_wdata[2*WC_W-1:WC_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xbus_sector.sv
module xbus_sector #(
  parameter int          AW    = 16,
  parameter int          LIM_W = 3,
  parameter int          WC_W  = 2,
  parameter logic [AW-1:0] BASE = 16'h0260,
  parameter logic [AW-1:0] STEP = 16'h2000
) (
  input  logic [AW-1:0]    addr,
  input  logic [LIM_W-1:0] lim,
  input  logic [WC_W-1:0]  wc_lo,
  input  logic [WC_W-1:0]  wc_hi,
  output logic [WC_W-1:0]  code
);
  localparam int BW = AW + LIM_W + 1;

  logic [BW-1:0] bound;
  logic          upper;

  always_comb begin
    bound = BW'(BASE) + BW'(lim) * BW'(STEP);
    upper = (lim != '0) && (BW'(addr) >= bound);
    code  = upper ? wc_hi : wc_lo;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int WC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [WC_W-1:0] code_in,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  input  logic [DW-1:0]   ad_in,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic            ale,
  output logic            wr_n,
  output logic            rd_n
);
  import xbus_pkg::*;

  xb_state_e       st;
  logic [WC_W-1:0] cnt;
  logic [WC_W-1:0] code_q;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q;
  logic [DW-1:0]   rd_q;
  logic            rsp_q;
  logic            tail_q;

  assign tail_q    = (code_q == '1);
  assign req_ready = en && (st == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rd_q;
  assign hi_out    = addr_q[AW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      code_q <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          code_q <= code_in;
          st     <= ST_ADDR;
        end
        ST_ADDR: st <= ST_HOLD;
        ST_HOLD: begin
          st  <= ST_STRB;
          cnt <= tail_q ? code_q - WC_W'(1) : code_q;
        end
        ST_STRB: begin
          if (cnt != '0) begin
            cnt <= cnt - WC_W'(1);
          end else begin
            if (!wr_q) rd_q <= ad_in;
            if (tail_q) begin
              st <= ST_TAIL;
            end else begin
              st    <= ST_IDLE;
              rsp_q <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          st    <= ST_IDLE;
          rsp_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ale    = 1'b0;
    ad_out = addr_q[DW-1:0];
    ad_oe  = 1'b0;
    wr_n   = 1'b1;
    rd_n   = 1'b1;
    case (st)
      ST_ADDR: begin
        ale   = 1'b1;
        ad_oe = 1'b1;
      end
      ST_HOLD: ad_oe = 1'b1;
      ST_STRB: begin
        if (wr_q) begin
          wr_n   = 1'b0;
          ad_out = wd_q;
          ad_oe  = 1'b1;
        end else begin
          rd_n = 1'b0;
        end
      end
      ST_TAIL: begin
        if (req_valid) begin
          ale    = 1'b1;
          ad_out = req_addr[DW-1:0];
          ad_oe  = 1'b1;
        end else if (wr_q) begin
          ad_out = wd_q;
          ad_oe  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux #(
  parameter int DW = 8,
  parameter int HW = 8,
  parameter int CW = 3
) (
  input  logic          own,
  input  logic [DW-1:0] x_ad_out,
  input  logic          x_ad_oe,
  input  logic [HW-1:0] x_hi_out,
  input  logic [CW-1:0] x_ctl_out,
  input  logic [DW-1:0] gp_ad_out,
  input  logic [DW-1:0] gp_ad_oe,
  input  logic [HW-1:0] gp_hi_out,
  input  logic [HW-1:0] gp_hi_oe,
  input  logic [CW-1:0] gp_ctl_out,
  input  logic [CW-1:0] gp_ctl_oe,
  output logic [DW-1:0] pad_ad_out,
  output logic [DW-1:0] pad_ad_oe,
  output logic [HW-1:0] pad_hi_out,
  output logic [HW-1:0] pad_hi_oe,
  output logic [CW-1:0] pad_ctl_out,
  output logic [CW-1:0] pad_ctl_oe
);
  for (genvar i = 0; i < DW; i++) begin : g_ad
    assign pad_ad_out[i] = own ? x_ad_out[i] : gp_ad_out[i];
    assign pad_ad_oe[i]  = own ? x_ad_oe     : gp_ad_oe[i];
  end
  for (genvar i = 0; i < HW; i++) begin : g_hi
    assign pad_hi_out[i] = own ? x_hi_out[i] : gp_hi_out[i];
    assign pad_hi_oe[i]  = own | gp_hi_oe[i];
  end
  for (genvar i = 0; i < CW; i++) begin : g_ctl
    assign pad_ctl_out[i] = own ? x_ctl_out[i] : gp_ctl_out[i];
    assign pad_ctl_oe[i]  = own | gp_ctl_oe[i];
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int            AW    = 16,
  parameter int            DW    = 8,
  parameter int            LIM_W = 3,
  parameter int            WC_W  = 2,
  parameter logic [15:0]   BASE  = 16'h0260,
  parameter logic [15:0]   STEP  = 16'h2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [DW-1:0]    gp_ad_out,
  input  logic [DW-1:0]    gp_ad_oe,
  input  logic [AW-DW-1:0] gp_hi_out,
  input  logic [AW-DW-1:0] gp_hi_oe,
  input  logic [2:0]       gp_ctl_out,
  input  logic [2:0]       gp_ctl_oe,
  input  logic [DW-1:0]    pad_ad_in,
  output logic [DW-1:0]    pad_ad_out,
  output logic [DW-1:0]    pad_ad_oe,
  output logic [AW-DW-1:0] pad_hi_out,
  output logic [AW-DW-1:0] pad_hi_oe,
  output logic [2:0]       pad_ctl_out,
  output logic [2:0]       pad_ctl_oe
);
  localparam int HW = AW - DW;

  logic             cfg_en;
  logic [LIM_W-1:0] cfg_lim;
  logic [WC_W-1:0]  cfg_wc_lo;
  logic [WC_W-1:0]  cfg_wc_hi;
  logic [WC_W-1:0]  sel_code;
  logic [DW-1:0]    x_ad_out;
  logic             x_ad_oe;
  logic [HW-1:0]    x_hi_out;
  logic             x_ale;
  logic             x_wr_n;
  logic             x_rd_n;

  xbus_cfg #(.LIM_W(LIM_W), .WC_W(WC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en(cfg_en), .lim(cfg_lim),
    .wc_lo(cfg_wc_lo), .wc_hi(cfg_wc_hi)
  );

  xbus_sector #(.AW(AW), .LIM_W(LIM_W), .WC_W(WC_W),
                .BASE(AW'(BASE)), .STEP(AW'(STEP))) u_sector (
    .addr(req_addr), .lim(cfg_lim), .wc_lo(cfg_wc_lo),
    .wc_hi(cfg_wc_hi), .code(sel_code)
  );

  xbus_seq #(.AW(AW), .DW(DW), .WC_W(WC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(cfg_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .code_in(sel_code),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ad_in(pad_ad_in),
    .ad_out(x_ad_out), .ad_oe(x_ad_oe), .hi_out(x_hi_out),
    .ale(x_ale), .wr_n(x_wr_n), .rd_n(x_rd_n)
  );

  xbus_pinmux #(.DW(DW), .HW(HW), .CW(3)) u_pinmux (
    .own(cfg_en), .x_ad_out(x_ad_out), .x_ad_oe(x_ad_oe),
    .x_hi_out(x_hi_out), .x_ctl_out({x_ale, x_wr_n, x_rd_n}),
    .gp_ad_out(gp_ad_out), .gp_ad_oe(gp_ad_oe), .gp_hi_out(gp_hi_out),
    .gp_hi_oe(gp_hi_oe), .gp_ctl_out(gp_ctl_out), .gp_ctl_oe(gp_ctl_oe),
    .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe), .pad_hi_out(pad_hi_out),
    .pad_hi_oe(pad_hi_oe), .pad_ctl_out(pad_ctl_out), .pad_ctl_oe(pad_ctl_oe)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int DW = 8,
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] pad_ad_oe,
  input logic [HW-1:0] pad_hi_oe,
  input logic [2:0]    pad_ctl_out,
  input logic [2:0]    pad_ctl_oe
);
  a_r2_pins_owned: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pad_hi_oe == '1) && (pad_ctl_oe == 3'b111));

  a_r3_ale_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pad_ctl_out[2]) |-> (pad_ad_oe == '1));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !(!pad_ctl_out[1] && !pad_ctl_out[0]));

  a_r4_ale_off_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (!pad_ctl_out[1] || !pad_ctl_out[0])) |-> !pad_ctl_out[2]);

  a_r4_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pad_ctl_out[0]) |-> (pad_ad_oe == '0));

  a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(cfg_en), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .pad_ad_oe(pad_ad_oe),
  .pad_hi_oe(pad_hi_oe), .pad_ctl_out(pad_ctl_out), .pad_ctl_oe(pad_ctl_oe)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [7:0] gp_ad_out = 8'h3C, gp_ad_oe = 8'h0F, gp_hi_out = 8'hC3, gp_hi_oe = 8'hF0;
  logic [2:0] gp_ctl_out = 3'b010, gp_ctl_oe = 3'b101;
  logic [7:0] pad_ad_in, pad_ad_out, pad_ad_oe, pad_hi_out, pad_hi_oe;
  logic [2:0] pad_ctl_out, pad_ctl_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;
  assign pad_ad_in = pad_hi_out ^ 8'hA5;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .gp_ad_out(gp_ad_out),
    .gp_ad_oe(gp_ad_oe), .gp_hi_out(gp_hi_out), .gp_hi_oe(gp_hi_oe),
    .gp_ctl_out(gp_ctl_out), .gp_ctl_oe(gp_ctl_oe), .pad_ad_in(pad_ad_in),
    .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe), .pad_hi_out(pad_hi_out),
    .pad_hi_oe(pad_hi_oe), .pad_ctl_out(pad_ctl_out), .pad_ctl_oe(pad_ctl_oe)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [2:0]  lim;
    logic [1:0]  wlo;
    logic [1:0]  whi;
    logic [1:0]  exp_code;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1234, 8'h11, 3'd0, 2'd0, 2'd3, 2'd0},
    '{1'b0, 16'hF000, 8'h00, 3'd0, 2'd1, 2'd3, 2'd1},
    '{1'b1, 16'h4260, 8'h22, 3'd2, 2'd0, 2'd2, 2'd2},
    '{1'b0, 16'h425F, 8'h00, 3'd2, 2'd1, 2'd2, 2'd1},
    '{1'b0, 16'hE260, 8'h00, 3'd7, 2'd0, 2'd3, 2'd3},
    '{1'b1, 16'hE25F, 8'h33, 3'd7, 2'd2, 2'd0, 2'd2},
    '{1'b0, 16'h2260, 8'h00, 3'd1, 2'd3, 2'd0, 2'd0},
    '{1'b1, 16'h8000, 8'h44, 3'd3, 2'd0, 2'd3, 2'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] sector_code(input logic [15:0] a, input logic [2:0] l,
                                             input logic [1:0] lo, input logic [1:0] hi);
    int bound;
    bound = 32'h0260 + int'(l) * 32'h2000;
    return (l != 0 && int'(a) >= bound) ? hi : lo;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // Runs one access from a falling edge; returns on the response falling edge.
  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                        input int code, input bit chain, input logic [15:0] next_a,
                        input bit mid_cfg);
    int strobes = 0;
    int lat = 0;
    int sl;
    bit bad_data = 0;
    sl = 1 + ((code > 2) ? 2 : code);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check("R3 ale high in cycle 1", pad_ctl_out[2], 1'b1);
        check("R3 low address on bus", pad_ad_out, a[7:0]);
        check("R3 high address", pad_hi_out, a[15:8]);
        check("R9 ready low while busy", req_ready, 1'b0);
      end
      if (i == 2) begin
        check("R3 ale low in cycle 2", pad_ctl_out[2], 1'b0);
        check("R3 address held", {pad_ad_oe, pad_ad_out}, {8'hFF, a[7:0]});
      end
      if (i >= 3 && i < 3 + sl) begin
        if (!(wr ? !pad_ctl_out[1] : !pad_ctl_out[0])) bad_data = 1;
        if (wr && (pad_ad_out !== wd || pad_ad_oe !== 8'hFF)) bad_data = 1;
        if (!wr && pad_ad_oe !== 8'h00) bad_data = 1;
      end
      if (!pad_ctl_out[1] || !pad_ctl_out[0]) strobes++;
      if (code == 3 && i == 6) begin
        if (chain) begin
          check("R8 trailing ale with next request", pad_ctl_out[2], 1'b1);
          check("R8 next low address", pad_ad_out, next_a[7:0]);
        end else begin
          check("R8 no trailing ale when idle next", pad_ctl_out[2], 1'b0);
        end
      end
      if (rsp_valid) begin
        lat = i;
        break;
      end
      if (i == 1) begin
        req_valid = 1'b0;
        if (mid_cfg) begin
          cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h0F;
        end
      end
      if (i == 2) cfg_we = 1'b0;
      if (chain && i == 5) begin
        req_valid = 1'b1; req_addr = next_a; req_write = 1'b0;
      end
    end
    check("R4 strobe length", strobes, sl);
    check("R4 strobe kind and bus data", bad_data, 1'b0);
    check(mid_cfg ? "R9 code fixed at accept" : "R5 latency", lat, 4 + code);
    if (!wr) check("R6 read data", rsp_rdata, a[15:8] ^ 8'hA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 ready low", req_ready, 1'b0);
    check("R1 rsp low", rsp_valid, 1'b0);
    check("R1 pads follow gp", {pad_ad_out, pad_ad_oe, pad_hi_out, pad_hi_oe, pad_ctl_out, pad_ctl_oe},
          {gp_ad_out, gp_ad_oe, gp_hi_out, gp_hi_oe, gp_ctl_out, gp_ctl_oe});
    rst_n = 1'b1;
    @(negedge clk);
    cfg_write(2'd0, 8'h01);
    check("R2 hi and ctl owned", {pad_hi_oe, pad_ctl_oe}, {8'hFF, 3'b111});
    check("R2 idle control levels", pad_ctl_out, 3'b011);
    check("R9 ready when idle", req_ready, 1'b1);

    for (int v = 0; v < NV; v++) begin
      cfg_write(2'd1, {5'd0, VECS[v].lim});
      cfg_write(2'd2, {4'd0, VECS[v].whi, VECS[v].wlo});
      check("R7 sector code", sector_code(VECS[v].addr, VECS[v].lim, VECS[v].wlo, VECS[v].whi),
            VECS[v].exp_code);
      access(VECS[v].wr, VECS[v].addr, VECS[v].wd, int'(VECS[v].exp_code), 1'b0, 16'h0, 1'b0);
    end

    // R8 collision: next request arrives in the tail cycle
    cfg_write(2'd1, 8'd0);
    cfg_write(2'd2, 8'h03);
    access(1'b1, 16'h5A5A, 8'h77, 3, 1'b1, 16'h1299, 1'b0);
    access(1'b0, 16'h1299, 8'h00, 3, 1'b0, 16'h0, 1'b0);

    // R9 configuration write during an access
    cfg_write(2'd2, 8'h00);
    access(1'b0, 16'h3301, 8'h00, 0, 1'b0, 16'h0, 1'b1);
    @(negedge clk);
    access(1'b0, 16'h3301, 8'h00, 3, 1'b0, 16'h0, 1'b0);

    // R2 disabling returns pins to general-purpose control
    cfg_write(2'd0, 8'h00);
    check("R2 pads follow gp after disable", {pad_ad_oe, pad_hi_out, pad_ctl_out, pad_ctl_oe},
          {gp_ad_oe, gp_hi_out, gp_ctl_out, gp_ctl_oe});
    check("R9 ready low while disabled", req_ready, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule